// File: doc/BRIEF.md
# I2C Target Receiver with Clock Stretching

This block is the receive-only target side of an I2C bus. It watches SCL and SDA through a two-flop synchroniser and recognises start and stop conditions. After a start it shifts in a 7-bit address, most significant bit first, followed by a direction bit. The address is compared with a configured value. When a write to this target is seen and acknowledge is enabled, the block pulls SDA low during the ninth clock. It then takes in data bytes the same way.

After every accepted byte the block holds SCL low. The hold begins at either the eighth or the ninth falling SCL edge, chosen by a configuration pin, and a one-cycle interrupt pulse marks its start. The byte stays readable while SCL is held. A register-style host write ends the hold in one of two ways: a write of all-ones to the data register, or a write to the control register with the release bit set. This hold on SCL is the block's only back-pressure. The bus cannot move on until the host has released the byte, so a received byte is never overwritten before it has been seen. Status pins report start seen, stop seen, acknowledge seen, the latched direction bit and a controller-mode flag, which is always low.

Top module: `i2c_stretch_target`

## Requirements
- R1: When SDA falls while SCL is high, `start_flag` becomes 1, `stop_flag` becomes 0, and address reception restarts.
- R2: When SDA rises while SCL is high, `stop_flag` becomes 1 and `start_flag` becomes 0. The block returns to idle, and `scl_hold` and `sda_low` both go to 0.
- R3: The first byte after a start is the address in bits 7..1, sent MSB first, followed by the direction in bit 0. `rw_flag` latches the direction bit, so 0 gives a receive and keeps it low. Each data byte appears on `rx_byte` MSB first once its eighth bit has been taken in. A direction bit of 1 is not served: there is no acknowledge and no hold.
- R4: With `ack_en` = 1, `sda_low` is 1 from the eighth to the ninth falling SCL edge after a matching write address or a data byte. With `ack_en` = 0, `sda_low` stays 0. `ack_flag` shows whether SDA was low at the ninth rising SCL edge.
- R5: With `wait_sel` = 0, `scl_hold` is set at the eighth falling SCL edge of each accepted byte. With `wait_sel` = 1, it is set at the ninth. Exactly one hold occurs per accepted byte.
- R6: `irq` is a one-cycle pulse, and it is issued in the cycle in which `scl_hold` is set.
- R7: While `scl_hold` is 1, a host write releases it on the next clock edge when either `host_sel` = 0 with `host_wdata` = 8'hFF, or `host_sel` = 1 with `host_wdata[0]` = 1. A data-register write of any other value leaves the hold in place.
- R8: `mst_flag` is 0 at all times.
- R9: If the address does not match, the block gives no acknowledge, no hold and no `irq` for any byte until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_hold | output | 1 | 1 = pull SCL low (stretch) |
| sda_low | output | 1 | 1 = pull SDA low (acknowledge) |
| own_addr | input | 7 | Configured target address |
| ack_en | input | 1 | Acknowledge enable |
| wait_sel | input | 1 | 0 = hold after 8th clock, 1 = after 9th |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = data register, 1 = control register |
| host_wdata | input | 8 | Host write data; control bit 0 = release |
| rx_byte | output | 8 | Last received data byte |
| irq | output | 1 | One-cycle pulse when a hold begins |
| start_flag | output | 1 | Start condition seen |
| stop_flag | output | 1 | Stop condition seen |
| ack_flag | output | 1 | SDA was low at the ninth clock |
| rw_flag | output | 1 | Latched direction bit (0 = receive) |
| mst_flag | output | 1 | Controller-mode flag, always 0 |

## Verification
The bound checker watches, on every cycle, the local relations between the block's outputs. These are: the single-cycle interrupt that coincides with the start of a hold, the release on the edge after either release write, and the rule that start and stop flags are never both set. Only the bench scenarios can show the behaviour that depends on bus sequences. This covers the position of the hold at the eighth or ninth clock and the acknowledge under each enable setting. It also covers bit order into the received byte, handling of a read direction bit, and the silence that follows each of the 127 non-matching addresses in the sweep.

// File: rtl/i2c_st_pkg.sv
package i2c_st_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/i2c_st_sync.sv
module i2c_st_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/i2c_st_cond.sv
module i2c_st_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_ev,
  output logic stop_ev
);
  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;
endmodule

// File: rtl/i2c_st_host.sv
module i2c_st_host
  import i2c_st_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int REL_BIT = 0
) (
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              release_req
);
  logic data_rel;
  logic ctrl_rel;

  assign data_rel    = (host_sel == SEL_DATA) && (host_wdata == {BYTE_W{1'b1}});
  assign ctrl_rel    = (host_sel == SEL_CTRL) && host_wdata[REL_BIT];
  assign release_req = host_wr && (data_rel || ctrl_rel);
endmodule

// File: rtl/i2c_st_engine.sv
module i2c_st_engine
  import i2c_st_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              release_req,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              wait_sel,
  output logic              scl_hold,
  output logic              sda_low,
  output logic              irq,
  output logic [ADDR_W:0]   rx_byte,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              ack_flag,
  output logic              rw_flag
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  phase_t            phase;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              ninth;
  logic              active;
  logic              byte_done;
  logic              addr_hit;

  assign active    = (phase == PH_ADDR) || (phase == PH_DATA);
  assign byte_done = (cnt == CNT_FULL);
  assign addr_hit  = (shreg[BYTE_W-1:1] == own_addr) && !shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      shreg      <= '0;
      cnt        <= '0;
      ninth      <= 1'b0;
      scl_hold   <= 1'b0;
      sda_low    <= 1'b0;
      irq        <= 1'b0;
      rx_byte    <= '0;
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      ack_flag   <= 1'b0;
      rw_flag    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (stop_ev) begin
        phase      <= PH_IDLE;
        cnt        <= '0;
        ninth      <= 1'b0;
        scl_hold   <= 1'b0;
        sda_low    <= 1'b0;
        stop_flag  <= 1'b1;
        start_flag <= 1'b0;
      end else if (start_ev) begin
        phase      <= PH_ADDR;
        cnt        <= '0;
        ninth      <= 1'b0;
        scl_hold   <= 1'b0;
        sda_low    <= 1'b0;
        start_flag <= 1'b1;
        stop_flag  <= 1'b0;
        ack_flag   <= 1'b0;
        rw_flag    <= 1'b0;
      end else begin
        if (release_req && scl_hold)
          scl_hold <= 1'b0;
        if (active && scl_rise) begin
          if (!byte_done) begin
            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            cnt   <= cnt + 1'b1;
          end else begin
            ninth    <= 1'b1;
            ack_flag <= !sda_lvl;
          end
        end
        if (active && scl_fall) begin
          if (byte_done && !ninth) begin
            if (phase == PH_ADDR) begin
              rw_flag <= shreg[0];
              if (addr_hit) begin
                sda_low <= ack_en;
                if (!wait_sel) begin
                  scl_hold <= 1'b1;
                  irq      <= 1'b1;
                end
              end else begin
                phase <= PH_SKIP;
                cnt   <= '0;
              end
            end else begin
              rx_byte <= shreg;
              sda_low <= ack_en;
              if (!wait_sel) begin
                scl_hold <= 1'b1;
                irq      <= 1'b1;
              end
            end
          end else if (ninth) begin
            ninth   <= 1'b0;
            cnt     <= '0;
            sda_low <= 1'b0;
            phase   <= PH_DATA;
            if (wait_sel) begin
              scl_hold <= 1'b1;
              irq      <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_st_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int REL_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_hold,
  output logic              sda_low,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              wait_sel,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [ADDR_W:0]   host_wdata,
  output logic [ADDR_W:0]   rx_byte,
  output logic              irq,
  output logic              start_flag,
  output logic              stop_flag,
  output logic              ack_flag,
  output logic              rw_flag,
  output logic              mst_flag
);
  localparam int BYTE_W = ADDR_W + 1;

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_ev, stop_ev, release_req;

  i2c_st_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_st_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_st_cond u_cond (
    .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_st_host #(.BYTE_W(BYTE_W), .REL_BIT(REL_BIT)) u_host (
    .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
    .release_req(release_req)
  );

  i2c_st_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .start_ev(start_ev), .stop_ev(stop_ev), .release_req(release_req),
    .own_addr(own_addr), .ack_en(ack_en), .wait_sel(wait_sel),
    .scl_hold(scl_hold), .sda_low(sda_low), .irq(irq), .rx_byte(rx_byte),
    .start_flag(start_flag), .stop_flag(stop_flag),
    .ack_flag(ack_flag), .rw_flag(rw_flag)
  );

  assign mst_flag = 1'b0;
endmodule

// File: rtl/i2c_stretch_target_chk.sv
module i2c_stretch_target_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_hold,
  input logic              irq,
  input logic              host_wr,
  input logic              host_sel,
  input logic [BYTE_W-1:0] host_wdata,
  input logic              start_flag,
  input logic              stop_flag
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6
  AST_IRQ_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_hold); // R6
  AST_HOLD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> irq); // R5
  AST_RELEASE_BY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && host_wr && !host_sel && host_wdata == {BYTE_W{1'b1}}) |=> !scl_hold); // R7
  AST_RELEASE_BY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && host_wr && host_sel && host_wdata[0]) |=> !scl_hold); // R7
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_flag && stop_flag)); // R1
endmodule

bind i2c_stretch_target i2c_stretch_target_chk #(.BYTE_W(ADDR_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_hold(scl_hold), .irq(irq),
  .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
  .start_flag(start_flag), .stop_flag(stop_flag)
);

// File: tb/i2c_stretch_target_bench.sv
module i2c_stretch_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 8;
  localparam logic [6:0] OWN = 7'h5B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic bus_scl, bus_sda;
  logic scl_hold, sda_low;
  logic [6:0] own_addr = OWN;
  logic ack_en = 1'b1, wait_sel = 1'b0;
  logic host_wr = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] rx_byte;
  logic irq, start_flag, stop_flag, ack_flag, rw_flag, mst_flag;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  bit rel_mode = 0;
  bit poke_other = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_scl = m_scl & ~scl_hold;
  assign bus_sda = m_sda & ~sda_low;

  i2c_stretch_target u_i2c_stretch_target (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_hold(scl_hold), .sda_low(sda_low), .own_addr(own_addr),
    .ack_en(ack_en), .wait_sel(wait_sel), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .rx_byte(rx_byte),
    .irq(irq), .start_flag(start_flag), .stop_flag(stop_flag),
    .ack_flag(ack_flag), .rw_flag(rw_flag), .mst_flag(mst_flag)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high;
    while (!bus_scl) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic release_hold;
    if (poke_other) begin
      host_write(1'b0, 8'h3C);
      idle(3);
      check(scl_hold == 1'b1, "R7 non-ones data write kept hold", scl_hold, 1);
    end
    if (rel_mode) host_write(1'b1, 8'h01);
    else          host_write(1'b0, 8'hFF);
    idle(1);
    check(scl_hold == 1'b0, "R7 release", scl_hold, 0);
  endtask

  task automatic do_start;
    m_sda = 1'b1; m_scl = 1'b1; idle(GAP);
    m_sda = 1'b0; idle(GAP);
    m_scl = 1'b0; idle(GAP);
  endtask

  task automatic do_stop;
    m_sda = 1'b0; idle(GAP);
    m_scl = 1'b1; wait_scl_high; idle(GAP);
    m_sda = 1'b1; idle(GAP);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked,
                           output bit s8, output bit s9);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; idle(GAP);
      m_scl = 1'b1; wait_scl_high; idle(GAP);
      m_scl = 1'b0; idle(GAP);
    end
    s8 = scl_hold;
    if (s8) release_hold;
    m_sda = 1'b1; idle(GAP);
    m_scl = 1'b1; wait_scl_high; idle(2);
    acked = !bus_sda;
    idle(GAP);
    m_scl = 1'b0; idle(GAP);
    s9 = scl_hold;
    if (s9) release_hold;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a, s8, s9;
    int i0;
    logic [7:0] dbyte;
    idle(3);
    // Reset state
    check(scl_hold == 0 && sda_low == 0, "R2 reset lines released", {scl_hold, sda_low}, 0);
    check(start_flag == 0 && stop_flag == 0, "R1 reset flags", {start_flag, stop_flag}, 0);
    check(irq == 0 && mst_flag == 0, "R8 reset irq/mst", {irq, mst_flag}, 0);
    rst_n = 1'b1;
    idle(4);

    // Configuration sweep: hold position x ack enable x release method
    for (int cfg = 0; cfg < 8; cfg++) begin
      wait_sel = cfg[0]; ack_en = cfg[1]; rel_mode = cfg[2];
      poke_other = (cfg == 3 || cfg == 4);
      do_start;
      check(start_flag == 1 && stop_flag == 0, "R1 start seen", {start_flag, stop_flag}, 2);
      i0 = irq_cnt;
      send_byte({OWN, 1'b0}, a, s8, s9);
      check(a == ack_en, "R4 address ack", a, ack_en);
      check(s8 == !wait_sel && s9 == wait_sel, "R5 address hold point", {s8, s9}, {!wait_sel, wait_sel});
      check(irq_cnt - i0 == 1, "R6 one irq per address", irq_cnt - i0, 1);
      check(rw_flag == 0, "R3 write direction", rw_flag, 0);
      for (int k = 0; k < 3; k++) begin
        dbyte = (8'h5A ^ (8'(k) * 8'h33)) ^ {cfg[2:0], 5'b0};
        if (k == 2) dbyte = 8'hFF;
        i0 = irq_cnt;
        send_byte(dbyte, a, s8, s9);
        check(rx_byte == dbyte, "R3 data byte MSB first", rx_byte, dbyte);
        check(a == ack_en, "R4 data ack", a, ack_en);
        check(ack_flag == ack_en, "R4 ack flag", ack_flag, ack_en);
        check(s8 == !wait_sel && s9 == wait_sel, "R5 data hold point", {s8, s9}, {!wait_sel, wait_sel});
        check(irq_cnt - i0 == 1, "R6 one irq per byte", irq_cnt - i0, 1);
        check(mst_flag == 0, "R8 controller flag low", mst_flag, 0);
      end
      do_stop;
      check(stop_flag == 1 && start_flag == 0, "R2 stop seen", {stop_flag, start_flag}, 2);
      check(scl_hold == 0 && sda_low == 0, "R2 lines released after stop", {scl_hold, sda_low}, 0);
    end
    poke_other = 0;

    // Read direction is not served
    wait_sel = 1'b1; ack_en = 1'b1; rel_mode = 1'b0;
    do_start;
    i0 = irq_cnt;
    send_byte({OWN, 1'b1}, a, s8, s9);
    check(rw_flag == 1, "R3 read direction latched", rw_flag, 1);
    check(a == 0 && s8 == 0 && s9 == 0, "R3 read not acked or held", {a, s8, s9}, 0);
    check(irq_cnt == i0, "R3 no irq on read", irq_cnt - i0, 0);
    do_stop;

    // Address sweep over every 7-bit value
    wait_sel = 1'b0;
    for (int ad = 0; ad < 128; ad++) begin
      bit hit;
      hit = (7'(ad) == OWN);
      do_start;
      i0 = irq_cnt;
      send_byte({7'(ad), 1'b0}, a, s8, s9);
      check(a == hit, "R9 address ack only on match", a, hit);
      check((s8 | s9) == hit, "R9 hold only on match", s8 | s9, hit);
      check(irq_cnt - i0 == int'(hit), "R9 irq only on match", irq_cnt - i0, hit);
      i0 = irq_cnt;
      send_byte(8'hC3, a, s8, s9);
      check(a == hit && (s8 | s9) == hit, "R9 following byte ignored unless matched", {a, s8 | s9}, {hit, hit});
      check(irq_cnt - i0 == int'(hit), "R9 following byte irq", irq_cnt - i0, hit);
      if (hit) check(rx_byte == 8'hC3, "R3 data after sweep match", rx_byte, 8'hC3);
      do_stop;
    end

    // Release write while no hold changes nothing
    host_write(1'b0, 8'hFF);
    host_write(1'b1, 8'h01);
    idle(2);
    check(scl_hold == 0 && irq_cnt > 0, "R7 idle release no effect", scl_hold, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule